// File: doc/BRIEF.md
# Inbound DMA Address Translation Unit

This block turns an address seen on the device side of a DMA bridge into a system address. Each request carries a 64-bit bus address and the number of the downstream port it came in on. The unit sorts the address into one of five windows. Each window has its own rule for translation, its own page size and its own barrier bit.

Two windows are direct. The wide direct window passes the low address bits straight through. The narrow direct window joins a per-port upper-address register to the low 30 address bits. The other three windows use page tables held in flip-flop arrays. The small-page 32-bit window and the 16 GB super-page 40-bit window share one table, which is split by mode and by port. The 64 MB-page 40-bit window has its own table. Software loads both tables, the per-port registers and the small-page size through a single write port.

Every request gets a registered result one cycle later. The result is either a valid system address with its barrier flag, or a one-cycle miss pulse.

Top module: `dma_addr_xlate`

## Requirements
- R1: When bus bit 63 is set and bits 61:54 are all zero, the result is valid. The system address is bus bits 53:0 and the barrier output equals bus bit 62.
- R2: When bus bit 63 is set and any of bits 61:54 is one, the result is a miss.
- R3: A bus address from 0x8000_0000 to 0xFFFF_FFFF gives a valid result. The system address is bits 53:30 of the register for the request's port joined with bus bits 29:0. The barrier output equals bus bit 30.
- R4: A bus address below 0x8000_0000 has bus bit 30 as its barrier flag, and that bit is stripped from the offset. The page index is bus bits 29:0 shifted right by 12+2*code, where code is the 2-bit page-size code (reset value 3, which gives 256 KB pages). The entry used is shared-table entry 64 plus the index. An index of 64 or more is a miss. A hit returns the entry's page-aligned base ORed with the in-page offset.
- R5: A bus address from 0x40_0000_0000 to 0x7F_FFFF_FFFF uses the 40-bit table. The index is bus bits 37:26 (64 MB pages). An index of 64 or more is a miss. A hit merges the base with bus bits 25:0, and the barrier output is 0.
- R6: A bus address from 0x80_0000_0000 to 0xFF_FFFF_FFFF uses shared-table entry port*32 + bus bits 38:34 (16 GB pages). A hit merges the base with bus bits 33:0, and the barrier output is 0.
- R7: A table entry is valid only when its bit 63 is set; its bits 53:0 hold the base. A request that selects an invalid entry is a miss.
- R8: A bus address that lies in none of the five windows is a miss.
- R9: A request presented in one cycle gives out_valid or out_miss, never both, in the next cycle. With no request, both outputs are low. On a miss, out_addr and out_barrier are zero.
- R10: Write selects are: 0 for the shared table, 1 for the 40-bit table, 2 for the per-port register (index is the port, data bits 53:30 are kept), and 3 for the page-size code (data bits 1:0). A write is used by requests from the next cycle on. A request in the same cycle as a write sees the old contents.
- R11: After reset the outputs are low, every table entry is invalid, the per-port registers are zero and the page-size code is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 64 | Bus-side DMA address |
| req_port | input | 1 | Downstream port number of the request |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target select (see R10) |
| wr_idx | input | 7 | Table entry or port index |
| wr_data | input | 64 | Write data |
| out_valid | output | 1 | Translation succeeded |
| out_miss | output | 1 | One-cycle miss or error pulse |
| out_barrier | output | 1 | Barrier flag of the translated access |
| out_addr | output | 54 | System-side address |

## Verification
The result of a request presented before rising edge N is registered at edge N. The monitor samples it 1 ns after that same edge and pops the matching expected item from the scoreboard queue. When no request was captured at an edge, the monitor expects both result outputs to be low.

A configuration write registered at edge N affects only requests captured at edge N+1 or later. The driver computes each expected value from its own shadow copy of the tables at the moment it drives the request. For a request issued in the same cycle as a write, the expected value is computed before the shadow copy is updated. Inputs change only on falling edges.

// File: rtl/dax_pkg.sv
package dax_pkg;

    localparam int BUS_AW      = 64;
    localparam int SYS_AW      = 54;
    localparam int D32_SPLIT   = 30;
    localparam int M40_SHIFT   = 26;
    localparam int SUPER_SHIFT = 34;
    localparam int PCODE_W     = 2;
    localparam int PCODE_RESET = 3;
    localparam int BASE_SHIFT  = 12;
    localparam int VALID_BIT   = 63;

    typedef enum logic [2:0] {
        WIN_NONE = 3'd0,
        WIN_D64  = 3'd1,
        WIN_D32  = 3'd2,
        WIN_M32  = 3'd3,
        WIN_M40  = 3'd4,
        WIN_M40S = 3'd5
    } win_e;

    typedef enum logic [1:0] {
        WSEL_SHARED = 2'd0,
        WSEL_M40    = 2'd1,
        WSEL_DIR    = 2'd2,
        WSEL_PAGE   = 2'd3
    } wsel_e;

    typedef struct packed {
        logic              valid;
        logic [SYS_AW-1:0] base;
    } ate_t;

    typedef struct packed {
        logic              valid;
        logic              miss;
        logic              barrier;
        logic [SYS_AW-1:0] addr;
    } xres_t;

    function automatic logic [5:0] m32_shift(input logic [PCODE_W-1:0] code);
        return 6'(BASE_SHIFT + 2 * int'(code));
    endfunction

    function automatic logic [SYS_AW-1:0] low_mask(input logic [5:0] sh);
        return (SYS_AW'(1) << sh) - SYS_AW'(1);
    endfunction

    function automatic logic [SYS_AW-1:0] page_merge(input ate_t e,
                                                    input logic [SYS_AW-1:0] off,
                                                    input logic [SYS_AW-1:0] m);
        return (e.base & ~m) | (off & m);
    endfunction

endpackage

// File: rtl/dax_window_decode.sv
module dax_window_decode
    import dax_pkg::*;
(
    input  logic [BUS_AW-1:0] addr,
    output win_e              win,
    output logic              barrier,
    output logic              rsvd_bad
);

    always_comb begin
        win      = WIN_NONE;
        barrier  = 1'b0;
        rsvd_bad = 1'b0;
        if (addr[63]) begin
            win      = WIN_D64;
            barrier  = addr[62];
            rsvd_bad = |addr[61:SYS_AW];
        end else if (addr[62:40] != '0) begin
            win = WIN_NONE;
        end else if (addr[39]) begin
            win = WIN_M40S;
        end else if (addr[38]) begin
            win = WIN_M40;
        end else if (addr[37:32] != '0) begin
            win = WIN_NONE;
        end else if (addr[31]) begin
            win     = WIN_D32;
            barrier = addr[D32_SPLIT];
        end else begin
            win     = WIN_M32;
            barrier = addr[D32_SPLIT];
        end
    end

endmodule

// File: rtl/dax_xlate_table.sv
module dax_xlate_table
    import dax_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WR_IW = 7,
    localparam int RD_IW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WR_IW-1:0]  wr_idx,
    input  logic [63:0]       wr_data,
    input  logic [RD_IW-1:0]  rd_idx,
    output ate_t              rd_entry
);

    ate_t mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        ate_t r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (wr_en && int'(wr_idx) == i) begin
                r.valid <= wr_data[VALID_BIT];
                r.base  <= wr_data[SYS_AW-1:0];
            end
        end
        assign mem[i] = r;
    end

    always_comb begin
        if (int'(rd_idx) < DEPTH) rd_entry = mem[rd_idx];
        else                      rd_entry = '0;
    end

    // R10: a write lands in the addressed entry by the next cycle
    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_idx) < DEPTH) |=>
            (mem[$past(wr_idx[RD_IW-1:0])].valid == $past(wr_data[VALID_BIT])));

endmodule

// File: rtl/dax_cfg_regs.sv
module dax_cfg_regs
    import dax_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int WR_IW     = 7,
    localparam int DIR_W    = SYS_AW - D32_SPLIT
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [1:0]                      wr_sel,
    input  logic [WR_IW-1:0]                wr_idx,
    input  logic [63:0]                     wr_data,
    output logic [NUM_PORTS-1:0][DIR_W-1:0] dir_base,
    output logic [PCODE_W-1:0]              pcode
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [DIR_W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (wr_en && wr_sel == WSEL_DIR && int'(wr_idx) == p) begin
                r <= wr_data[SYS_AW-1:D32_SPLIT];
            end
        end
        assign dir_base[p] = r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcode <= PCODE_W'(PCODE_RESET);
        end else if (wr_en && wr_sel == WSEL_PAGE) begin
            pcode <= wr_data[PCODE_W-1:0];
        end
    end

    // R4: the page-size code moves only on a page-size write
    a_r4_page_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == WSEL_PAGE) |=> $stable(pcode));

endmodule

// File: rtl/dma_addr_xlate.sv
module dma_addr_xlate
    import dax_pkg::*;
#(
    parameter int NUM_PORTS          = 2,
    parameter int NUM_SUPER_PER_PORT = 32,
    parameter int NUM_SHARED         = 128,
    parameter int NUM_M40            = 64,
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int WR_IW  = $clog2((NUM_SHARED > NUM_M40) ? NUM_SHARED : NUM_M40)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    input  logic [PORT_W-1:0] req_port,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WR_IW-1:0]  wr_idx,
    input  logic [63:0]       wr_data,
    output logic              out_valid,
    output logic              out_miss,
    output logic              out_barrier,
    output logic [SYS_AW-1:0] out_addr
);

    localparam int SUPER_ENTRIES = NUM_PORTS * NUM_SUPER_PER_PORT;
    localparam int M32_ENTRIES   = NUM_SHARED - SUPER_ENTRIES;
    localparam int SH_IW         = $clog2(NUM_SHARED);
    localparam int M40_IW        = $clog2(NUM_M40);
    localparam int DIR_W         = SYS_AW - D32_SPLIT;

    win_e win;
    logic bar_raw;
    logic rsvd_bad;

    dax_window_decode u_decode (
        .addr     (req_addr),
        .win      (win),
        .barrier  (bar_raw),
        .rsvd_bad (rsvd_bad)
    );

    logic [NUM_PORTS-1:0][DIR_W-1:0] dir_base;
    logic [PCODE_W-1:0]              pcode;

    dax_cfg_regs #(.NUM_PORTS(NUM_PORTS), .WR_IW(WR_IW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .dir_base (dir_base),
        .pcode    (pcode)
    );

    // Index stage
    logic [5:0]        m32_sh;
    logic [29:0]       m32_page;
    logic [11:0]       m40_page;
    logic [4:0]        sup_page;
    logic              m32_ok, m40_ok, sup_ok;
    logic [SH_IW-1:0]  sh_rd_idx;
    logic [M40_IW-1:0] m40_rd_idx;

    always_comb begin
        m32_sh     = m32_shift(pcode);
        m32_page   = req_addr[D32_SPLIT-1:0] >> m32_sh;
        m40_page   = req_addr[37:M40_SHIFT];
        sup_page   = req_addr[38:SUPER_SHIFT];
        m32_ok     = int'(m32_page) < M32_ENTRIES;
        m40_ok     = int'(m40_page) < NUM_M40;
        sup_ok     = (int'(sup_page) < NUM_SUPER_PER_PORT) && (int'(req_port) < NUM_PORTS);
        m40_rd_idx = m40_page[M40_IW-1:0];
        if (win == WIN_M40S)
            sh_rd_idx = SH_IW'(int'(req_port) * NUM_SUPER_PER_PORT + int'(sup_page));
        else
            sh_rd_idx = SH_IW'(SUPER_ENTRIES) + m32_page[SH_IW-1:0];
    end

    ate_t sh_entry;
    ate_t m40_entry;

    dax_xlate_table #(.DEPTH(NUM_SHARED), .WR_IW(WR_IW)) u_shared_tbl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en && wr_sel == WSEL_SHARED),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (sh_rd_idx),
        .rd_entry (sh_entry)
    );

    dax_xlate_table #(.DEPTH(NUM_M40), .WR_IW(WR_IW)) u_m40_tbl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en && wr_sel == WSEL_M40),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (m40_rd_idx),
        .rd_entry (m40_entry)
    );

    // Merge stage
    xres_t nxt;

    always_comb begin
        nxt = '0;
        unique case (win)
            WIN_D64: begin
                if (rsvd_bad) begin
                    nxt.miss = 1'b1;
                end else begin
                    nxt.valid   = 1'b1;
                    nxt.barrier = bar_raw;
                    nxt.addr    = req_addr[SYS_AW-1:0];
                end
            end
            WIN_D32: begin
                nxt.valid   = 1'b1;
                nxt.barrier = bar_raw;
                nxt.addr    = {dir_base[req_port], req_addr[D32_SPLIT-1:0]};
            end
            WIN_M32: begin
                if (m32_ok && sh_entry.valid) begin
                    nxt.valid   = 1'b1;
                    nxt.barrier = bar_raw;
                    nxt.addr    = page_merge(sh_entry, SYS_AW'(req_addr[D32_SPLIT-1:0]),
                                             low_mask(m32_sh));
                end else begin
                    nxt.miss = 1'b1;
                end
            end
            WIN_M40: begin
                if (m40_ok && m40_entry.valid) begin
                    nxt.valid = 1'b1;
                    nxt.addr  = page_merge(m40_entry, req_addr[SYS_AW-1:0],
                                           low_mask(6'(M40_SHIFT)));
                end else begin
                    nxt.miss = 1'b1;
                end
            end
            WIN_M40S: begin
                if (sup_ok && sh_entry.valid) begin
                    nxt.valid = 1'b1;
                    nxt.addr  = page_merge(sh_entry, req_addr[SYS_AW-1:0],
                                           low_mask(6'(SUPER_SHIFT)));
                end else begin
                    nxt.miss = 1'b1;
                end
            end
            default: nxt.miss = 1'b1;
        endcase
        if (!req_valid) nxt = '0;
    end

    xres_t res_q;
    logic  win40_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            win40_q <= 1'b0;
        end else begin
            res_q   <= nxt;
            win40_q <= req_valid && (win == WIN_M40 || win == WIN_M40S);
        end
    end

    assign out_valid   = res_q.valid;
    assign out_miss    = res_q.miss;
    assign out_barrier = res_q.barrier;
    assign out_addr    = res_q.addr;

    // R9: success and miss are exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_miss));

    // R9: every request answers one cycle later
    a_r9_answer: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (out_valid || out_miss));

    // R9: no request, no result
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(out_valid || out_miss));

    // R1: wide direct window passes bits through with bit 62 as barrier
    a_r1_d64_pass: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[63] && req_addr[61:54] == '0) |=>
            (out_valid && out_addr == $past(req_addr[SYS_AW-1:0])
                       && out_barrier == $past(req_addr[62])));

    // R3: narrow direct window keeps the low 30 bits
    a_r3_d32_low: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[63:31] == 33'd1) |=>
            (out_valid && out_addr[D32_SPLIT-1:0] == $past(req_addr[D32_SPLIT-1:0])));

    // R5, R6: 40-bit windows carry no barrier
    a_r6_no_barrier40: assert property (@(posedge clk) disable iff (rst)
        (out_valid && win40_q) |-> !out_barrier);

    // R8: high bits outside any window miss
    a_r8_outside: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_addr[63] && req_addr[62:40] != '0) |=> out_miss);

endmodule

// File: tb/dma_addr_xlate_bench.sv
`timescale 1ns/1ps
module dma_addr_xlate_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [0:0]  req_port = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [6:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        out_valid, out_miss, out_barrier;
    logic [53:0] out_addr;

    always #2 clk = ~clk;

    dma_addr_xlate u_dma_addr_xlate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_port(req_port), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .out_valid(out_valid), .out_miss(out_miss),
        .out_barrier(out_barrier), .out_addr(out_addr)
    );

    typedef struct packed {
        logic        v;
        logic        m;
        logic        b;
        logic [53:0] a;
    } exp_t;

    exp_t  expq [$];
    string tagq [$];
    int    checks = 0;
    int    fails  = 0;
    logic  had;

    logic [63:0] sh_shared [128];
    logic [63:0] sh_m40 [64];
    logic [63:0] sh_dir [2];
    logic [1:0]  pcode = 2'd3;

    initial begin
        for (int i = 0; i < 128; i++) sh_shared[i] = '0;
        for (int i = 0; i < 64; i++) sh_m40[i] = '0;
        sh_dir[0] = '0;
        sh_dir[1] = '0;
    end

    function automatic exp_t from_entry(logic [63:0] ent, logic [63:0] a, int sh, logic bar);
        exp_t e = '0;
        logic [63:0] mask = (64'd1 << sh) - 64'd1;
        if (!ent[63]) e.m = 1'b1;
        else begin
            e.v = 1'b1;
            e.b = bar;
            e.a = 54'((ent & ~mask) | (a & mask));
        end
        return e;
    endfunction

    function automatic exp_t model(logic [63:0] a, int p);
        exp_t e = '0;
        int sh;
        logic [63:0] pg;
        if (a[63]) begin
            if (a[61:54] != '0) e.m = 1'b1;
            else begin e.v = 1'b1; e.b = a[62]; e.a = a[53:0]; end
        end else if (a < 64'h8000_0000) begin
            sh = 12 + 2 * int'(pcode);
            pg = {34'd0, a[29:0]} >> sh;
            if (pg >= 64) e.m = 1'b1;
            else e = from_entry(sh_shared[64 + int'(pg)], {34'd0, a[29:0]}, sh, a[30]);
        end else if (a <= 64'hFFFF_FFFF) begin
            e.v = 1'b1; e.b = a[30]; e.a = {sh_dir[p][53:30], a[29:0]};
        end else if (a >= 64'h40_0000_0000 && a <= 64'h7F_FFFF_FFFF) begin
            pg = {52'd0, a[37:26]};
            if (pg >= 64) e.m = 1'b1;
            else e = from_entry(sh_m40[int'(pg)], a, 26, 1'b0);
        end else if (a >= 64'h80_0000_0000 && a <= 64'hFF_FFFF_FFFF) begin
            e = from_entry(sh_shared[p * 32 + int'(a[38:34])], a, 34, 1'b0);
        end else begin
            e.m = 1'b1;
        end
        return e;
    endfunction

    task automatic check(string tag, exp_t act, exp_t exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got v=%0b m=%0b b=%0b a=%h, expected v=%0b m=%0b b=%0b a=%h",
                     tag, act.v, act.m, act.b, act.a, exp.v, exp.m, exp.b, exp.a);
        end
    endtask

    task automatic shadow_write(logic [1:0] sel, int idx, logic [63:0] data);
        case (sel)
            2'd0: sh_shared[idx] = data;
            2'd1: sh_m40[idx] = data;
            2'd2: sh_dir[idx] = data;
            default: pcode = data[1:0];
        endcase
    endtask

    task automatic send(logic [63:0] a, int p, string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_port  = 1'(p);
        expq.push_back(model(a, p));
        tagq.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(logic [1:0] sel, int idx, logic [63:0] data);
        @(negedge clk);
        req_valid = 1'b0;
        wr_en = 1'b1; wr_sel = sel; wr_idx = 7'(idx); wr_data = data;
        shadow_write(sel, idx, data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R10: request and write in the same cycle; request sees the old table
    task automatic wr_and_send(logic [1:0] sel, int idx, logic [63:0] data,
                               logic [63:0] a, int p, string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = 7'(idx); wr_data = data;
        req_valid = 1'b1; req_addr = a; req_port = 1'(p);
        expq.push_back(model(a, p));
        tagq.push_back(tag);
        shadow_write(sel, idx, data);
        @(negedge clk);
        wr_en = 1'b0;
        req_valid = 1'b0;
    endtask

    // Monitor: result of a request captured at an edge is checked 1 ns later
    initial begin
        forever begin
            @(posedge clk);
            had = req_valid && !rst;
            #1;
            if (!rst) begin
                if (had) begin
                    if (expq.size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R9: result with empty scoreboard, got v=%0b m=%0b, expected none",
                                 out_valid, out_miss);
                    end else begin
                        check(tagq.pop_front(), {out_valid, out_miss, out_barrier, out_addr},
                              expq.pop_front());
                    end
                end else begin
                    check("R9 idle", {out_valid, out_miss, out_barrier, out_addr}, '0);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, got hang, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset outputs", {out_valid, out_miss, out_barrier, out_addr}, '0);
        rst = 1'b0;

        // R11: empty tables and zero port registers after reset
        send(64'h0, 0, "R11 empty table");
        send(64'h8000_1234, 1, "R11 zero port register");
        idle();

        // R1, R2: wide direct window
        send(64'hC000_0000_1234_5678, 0, "R1 barrier set");
        send(64'h803F_FFFF_FFFF_FFF0, 1, "R1 top offset");
        send(64'hA000_0000_0000_0010, 0, "R2 msi bit");
        send(64'h8040_0000_0000_0000, 0, "R2 reserved bit");
        idle();

        // R3: narrow direct window per port
        wr(2'd2, 0, 64'h0000_0012_C000_0000);
        wr(2'd2, 1, 64'h003F_FFFF_C000_0000);
        send(64'hC000_1234, 0, "R3 port0 barrier");
        send(64'h8ABC_DEF0, 1, "R3 port1");
        send(64'h8000_0000, 0, "R3 window start");
        idle();

        // R4, R7: small-page window
        wr(2'd0, 65, 64'h8000_0055_0000_0000);
        send(64'h0004_0010, 0, "R4 page1 256K");
        send(64'h4004_0010, 0, "R4 barrier stripped");
        send(64'h0000_0000, 0, "R7 invalid page0");
        idle();
        wr(2'd3, 0, 64'd0);
        send(64'h0000_1ABC, 0, "R4 page1 4K");
        send(64'h0004_0000, 0, "R4 index past table");
        idle();
        wr(2'd3, 0, 64'd3);

        // R5: 40-bit table window
        wr(2'd1, 2, 64'h8000_0003_0400_0000);
        send(64'h40_0800_0123, 0, "R5 hit");
        send(64'h41_0000_0000, 0, "R5 index past table");
        send(64'h40_0C00_0000, 0, "R7 invalid m40 entry");
        idle();

        // R6: super-page window split by port
        wr(2'd0, 3, 64'h8000_0010_0000_0000);
        wr(2'd0, 35, 64'h8000_0020_0000_0000);
        send(64'h8C_0000_0055, 0, "R6 port0");
        send(64'h8C_0000_0055, 1, "R6 port1");
        send(64'hFF_FFFF_FFFF, 0, "R7 invalid super entry");
        idle();

        // R8: outside every window
        send(64'h1_0000_0000, 0, "R8 gap below m40");
        send(64'h100_0000_0000, 0, "R8 above 40 bits");
        send(64'h4000_0000_0000_0000, 0, "R8 bit62 only");
        idle();

        // R10: write timing
        wr_and_send(2'd1, 5, 64'h8000_0000_1400_0000, 64'h40_1400_0000, 0, "R10 same cycle old");
        send(64'h40_1400_0000, 0, "R10 next cycle new");
        idle();
        wr(2'd1, 5, 64'd0);
        send(64'h40_1400_0000, 0, "R10 invalidated");
        idle();

        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R9: pending results got %0d, expected 0", expq.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule